// File: doc/BRIEF.md
# Preamble-and-Checksum Transmit Framer

This block turns bytes written by a host into a serial bit stream for a radio data link. Raising the transmit enable starts bit timing afresh and sends an alternating one/zero fill pattern, one whole byte at a time, until the host has put a byte in the single-byte holding buffer. From then on each buffered byte is moved into the shift register at a byte boundary and sent most significant bit first. A one-cycle pulse marks each move, and a ready level shows that the buffer is free.

When checksum insertion is on, the block runs a 16-bit CRC over each group of six data bytes and sends the two check bytes straight after the sixth byte. It then starts a new group. When insertion is off, bytes go out exactly as written, so the host can append its own check bytes. If the buffer is empty at a byte boundary once data has started, the block sends one hang bit, releases the line and raises an idle flag. Any checksum for a partly loaded group is dropped. The bit rate is set by a strobe input, and the line output has its own drive enable for a tri-state pin.

Top module: `tx_framer`

## Requirements
- R1: One cycle after transmit enable rises, `ser_oe` is high and `ser_out` is 1. The fill pattern is the byte 0xAA (1,0,1,0,...), sent in whole bytes.
- R2: At least one fill byte precedes the first data byte. Data written before the first fill byte ends follows it directly. Otherwise more fill bytes are sent until data is present.
- R3: While transmit enable is low, `ser_oe`, `tx_rdy` and `tx_take` are low, and writes are discarded.
- R4: Every byte is sent most significant bit first, with one bit per `bit_stb` pulse. With checksum insertion off, data bytes appear unchanged and in write order.
- R5: With checksum insertion on, every sixth data byte is followed by a CRC-16 over those six bytes (polynomial 0x1021, start value 0xFFFF, no final inversion), high byte first.
- R6: When the buffer is empty at a byte boundary after data has started, one hang bit of value 1 is sent. After it `ser_oe` goes low and `idle` goes high. A partial checksum group sends no check bytes.
- R7: `tx_take` pulses for one cycle each time the buffered byte enters the shift register. `tx_rdy` is high exactly when the framer is sending and the buffer is empty. A write drops `tx_rdy` in the following cycle.
- R8: `idle` is low one cycle after transmit enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; a rising edge starts a transmission |
| crc_en | input | 1 | Checksum insertion enable; a rising edge starts a new group |
| bit_stb | input | 1 | One-cycle pulse per bit period |
| wr_stb | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | 8 | Byte written to the holding buffer |
| ser_out | output | 1 | Serial bit being sent |
| ser_oe | output | 1 | Drive enable for the serial output (low means high impedance) |
| tx_rdy | output | 1 | Holding buffer free while sending |
| tx_take | output | 1 | Pulse when the buffer byte moves to the shift register |
| idle | output | 1 | Set after an underrun ends transmission |

## Verification
The assertions assume that `bit_stb` lasts a single cycle and that `crc_en` is not toggled while a check byte is on the line. They also assume the host writes no more than once per byte period. The stimulus follows these rules. Strobes come from a free-running divider, the checksum enable is set only before transmit enable rises, and the host model writes only when it sees `tx_rdy` high, holding each strobe for one cycle.

// File: rtl/tx_framer.sv
module tx_framer #(
  parameter int unsigned BW    = 8,
  parameter int unsigned CW    = 16,
  parameter int unsigned GROUP = 6,
  parameter logic [15:0] POLY  = 16'h1021,
  parameter logic [15:0] SEED  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          crc_en,
  input  logic          bit_stb,
  input  logic          wr_stb,
  input  logic [BW-1:0] wr_data,
  output logic          ser_out,
  output logic          ser_oe,
  output logic          tx_rdy,
  output logic          tx_take,
  output logic          idle
);
  localparam int unsigned NCRC = CW / BW;
  localparam int unsigned BCW  = $clog2(BW);
  localparam int unsigned GCW  = $clog2(GROUP + 1);
  localparam int unsigned ICW  = $clog2(NCRC + 1);
  localparam logic [BCW-1:0] BLAST = BCW'(BW - 1);
  localparam logic [GCW-1:0] GFULL = GCW'(GROUP);
  localparam logic [ICW-1:0] ILAST = ICW'(NCRC - 1);

  function automatic logic [BW-1:0] fill_pat();
    logic [BW-1:0] f;
    for (int i = 0; i < int'(BW); i++) f[i] = i[0];
    return f;
  endfunction

  localparam logic [BW-1:0] FILL = fill_pat();

  function automatic logic [CW-1:0] crc_step(input logic [CW-1:0] c, input logic [BW-1:0] d);
    logic [CW-1:0] r;
    logic fb;
    r = c;
    for (int i = int'(BW) - 1; i >= 0; i--) begin
      fb = r[CW-1] ^ d[i];
      r  = {r[CW-2:0], 1'b0};
      if (fb) r = r ^ POLY[CW-1:0];
    end
    return r;
  endfunction

  typedef enum logic [2:0] {S_OFF, S_PRE, S_DATA, S_HANG, S_IDLE} st_t;

  st_t            st;
  logic           en_q, cen_q, full, take_q, idle_q;
  logic [BW-1:0]  sh, hold;
  logic [BCW-1:0] bcnt;
  logic [GCW-1:0] grp;
  logic [ICW-1:0] cidx;
  logic [CW-1:0]  crc, crc_part;

  wire start   = tx_en & ~en_q;
  wire active  = (st == S_PRE) || (st == S_DATA) || (st == S_HANG);
  wire edge_b  = tx_en && active && bit_stb && !start;
  wire bnd     = edge_b && (st != S_HANG) && (bcnt == BLAST);
  wire crc_due = (grp == GFULL);
  wire take    = bnd && !crc_due && full;
  wire grp_rst = !crc_en || !cen_q || start || (edge_b && st == S_HANG);

  assign crc_part = crc >> (BW * (NCRC - 1 - int'(cidx)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; cen_q <= 1'b0; take_q <= 1'b0;
      full <= 1'b0; hold <= '0;
    end else begin
      en_q   <= tx_en;
      cen_q  <= crc_en;
      take_q <= take;
      if (!tx_en) full <= 1'b0;
      else if (wr_stb) begin
        hold <= wr_data;
        full <= 1'b1;
      end else if (take) full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_OFF; sh <= '0; bcnt <= '0; idle_q <= 1'b0;
    end else if (!tx_en) begin
      st <= S_OFF;
    end else if (start) begin
      st <= S_PRE; sh <= FILL; bcnt <= '0; idle_q <= 1'b0;
    end else if (edge_b) begin
      if (st == S_HANG) begin
        st <= S_IDLE; idle_q <= 1'b1;
      end else if (bcnt != BLAST) begin
        sh   <= {sh[BW-2:0], 1'b0};
        bcnt <= bcnt + 1'b1;
      end else begin
        bcnt <= '0;
        if (crc_due) sh <= crc_part[BW-1:0];
        else if (full) begin
          sh <= hold; st <= S_DATA;
        end else if (st == S_DATA) begin
          sh <= '1; st <= S_HANG;
        end else sh <= FILL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || grp_rst) begin
      grp <= '0; cidx <= '0; crc <= SEED[CW-1:0];
    end else if (bnd && crc_due) begin
      if (cidx == ILAST) begin
        grp <= '0; cidx <= '0; crc <= SEED[CW-1:0];
      end else cidx <= cidx + 1'b1;
    end else if (take) begin
      crc <= crc_step(crc, hold);
      grp <= grp + 1'b1;
    end
  end

  assign ser_out = sh[BW-1];
  assign ser_oe  = active;
  assign tx_rdy  = ((st == S_PRE) || (st == S_DATA)) && !full;
  assign tx_take = take_q;
  assign idle    = idle_q;
endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic wr_stb,
  input logic ser_out,
  input logic ser_oe,
  input logic tx_rdy,
  input logic tx_take,
  input logic idle
);
  p_hiz_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !ser_oe);
  p_no_ready_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!tx_rdy && !tx_take));
  p_first_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> (ser_oe && ser_out));
  p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> !idle);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !ser_oe);
  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && tx_en) |=> !tx_rdy);
  p_take_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_take && tx_en && $past(tx_en) && !$past(wr_stb)) |-> tx_rdy);
endmodule

bind tx_framer tx_framer_chk u_chk (.*);

// File: tb/tx_framer_test.sv
`timescale 1ns/1ps
module tx_framer_test;
  logic clk = 0, rst_n = 0, tx_en = 0, crc_en = 0, bit_stb = 0, wr_stb = 0;
  logic [7:0] wr_data = 0;
  logic ser_out, ser_oe, tx_rdy, tx_take, idle;

  tx_framer uut (.clk(clk), .rst_n(rst_n), .tx_en(tx_en), .crc_en(crc_en), .bit_stb(bit_stb),
                 .wr_stb(wr_stb), .wr_data(wr_data), .ser_out(ser_out), .ser_oe(ser_oe),
                 .tx_rdy(tx_rdy), .tx_take(tx_take), .idle(idle));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, nb = 0, ntake = 0, scnt = 0;
  logic bits [0:4095];
  logic [7:0] dat [0:31];
  logic [7:0] expb [0:63];

  initial forever begin
    @(negedge clk);
    scnt++;
    bit_stb = (scnt % 4 == 0);
  end

  always @(negedge clk) begin
    if (bit_stb && ser_oe && nb < 4096) begin
      bits[nb] = ser_out;
      nb++;
    end
    if (tx_take) ntake++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int base);
    logic [15:0] c = 16'hFFFF;
    for (int j = 0; j < 6; j++)
      for (int b = 7; b >= 0; b--)
        c = (c[15] ^ dat[base+j][b]) ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] get_byte(input int p);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[7-b] = bits[p+b];
    return v;
  endfunction

  task automatic run_frame(input int len, input bit use_crc, input int delay);
    int t = 0, nexp = 0, k;
    logic [15:0] c;
    nb = 0; ntake = 0;
    crc_en = use_crc;
    @(negedge clk); tx_en = 1;
    @(negedge clk);
    chk(idle == 0, "R8 idle after enable", idle, 0);
    chk(ser_oe == 1 && ser_out == 1, "R1 first bit", {ser_oe, ser_out}, 3);
    repeat (delay) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      while (!tx_rdy) @(negedge clk);
      wr_stb = 1; wr_data = dat[i];
      @(negedge clk); wr_stb = 0;
    end
    while (!idle && t < 5000) begin @(negedge clk); t++; end
    chk(idle == 1, "R6 idle after underrun", idle, 1);
    chk(ser_oe == 0, "R6 line released", ser_oe, 0);
    tx_en = 0; crc_en = 0;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      expb[nexp++] = dat[i];
      if (use_crc && i % 6 == 5) begin
        c = ref_crc(i - 5);
        expb[nexp++] = c[15:8];
        expb[nexp++] = c[7:0];
      end
    end
    chk((nb - 1) % 8 == 0, "R6 single hang bit", (nb - 1) % 8, 0);
    k = (nb - 1) / 8 - nexp;
    chk(k >= 1, "R2 fill byte count", k, 1);
    if (delay == 0) chk(k == 1, "R2 early data follows first fill", k, 1);
    if (delay >= 80) chk(k >= 2, "R2 extra fill bytes", k, 2);
    for (int i = 0; i < k && i < 64; i++)
      chk(get_byte(8*i) == 8'hAA, "R1 fill pattern", get_byte(8*i), 8'hAA);
    for (int i = 0; i < nexp && k >= 0; i++)
      chk(get_byte(8*(k+i)) == expb[i], use_crc ? "R5 byte with checksum" : "R4 byte as written",
          get_byte(8*(k+i)), expb[i]);
    chk(bits[nb-1] == 1'b1, "R6 hang bit value", bits[nb-1], 1);
    chk(ntake == len, "R7 take pulses", ntake, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D2C));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ser_oe == 0 && tx_rdy == 0 && idle == 0 && tx_take == 0, "R3 reset state",
        {ser_oe, tx_rdy, idle, tx_take}, 0);

    wr_stb = 1; wr_data = 8'h3C; @(negedge clk); wr_stb = 0;
    repeat (40) @(negedge clk);
    chk(ser_oe == 0 && tx_rdy == 0 && ntake == 0, "R3 disabled quiet", {ser_oe, tx_rdy}, 0);
    nb = 0;
    tx_en = 1;
    repeat (100) @(negedge clk);
    chk(tx_rdy == 1, "R3 write while off discarded", tx_rdy, 1);
    for (int i = 0; i < nb; i++) chk(bits[i] == ((i % 2) == 0), "R3 only fill sent", bits[i], (i % 2) == 0);
    chk(ntake == 0, "R7 no take without data", ntake, 0);
    wr_stb = 1; wr_data = 8'h11; @(negedge clk); wr_stb = 0;
    @(negedge clk);
    chk(tx_rdy == 0, "R7 write drops ready", tx_rdy, 0);
    tx_en = 0;
    repeat (40) @(negedge clk);

    for (int i = 0; i < 32; i++) dat[i] = 8'($urandom);
    dat[0] = 8'h5A;
    run_frame(3, 1, 0);
    run_frame(6, 1, 0);
    run_frame(12, 1, 90);
    run_frame(5, 0, 0);
    for (int n = 0; n < 8; n++) begin
      for (int i = 0; i < 32; i++) dat[i] = 8'($urandom);
      if (dat[0] == 8'hAA) dat[0] = 8'h55;
      run_frame(1 + int'($urandom % 14), 1'($urandom % 2), ($urandom % 2) ? 0 : 90);
      repeat (10) @(negedge clk);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule